// File: doc/BRIEF.md
# Register-Mapped Network Port Interface

This block sits between the operand-read and writeback points of a single-issue integer pipeline and a set of on-chip network queues. A short window of architectural register numbers has no storage behind it. When an instruction names one of those numbers as a source, the operand comes from the front of that port's receive queue and is consumed when the instruction issues. When an instruction names one as its destination, the result goes into that port's transmit queue, and the register file is not written.

The pipeline presents both source indices and the register-file read data at decode. The block returns the final operands and a decode stall. At writeback the pipeline presents the destination index and the result. The block returns a writeback stall and the register-file write enable. An operand that the instruction does not use must be presented as index 0. Because the network ports look like ordinary registers, one ALU instruction can consume two incoming words and send one result without any load or store.

Top module: `netreg_if`

## Requirements
- R1: Source indices outside 24..27 pass the register-file read data straight to the operand and never cause a decode stall. Index 23 and index 28 are unmapped.
- R2: A source index of 24+k delivers the front word of receive queue k as the operand. The word is removed only in a cycle where the instruction issues (issue_valid high and issue_stall low).
- R3: When both sources name the same mapped register, operand A gets the oldest word and operand B gets the next one, and both are removed when the instruction issues.
- R4: issue_stall is high while the needed receive queues hold fewer words than the instruction reads. No word is removed while the instruction is stalled, and the instruction issues in the cycle after the missing word arrives.
- R5: A writeback to index 24+k pushes the result into transmit queue k and keeps rf_we low.
- R6: A writeback to a mapped register whose transmit queue is full raises wb_stall and pushes nothing. The result is pushed exactly once, in the first cycle that the queue has space.
- R7: A writeback to any other index raises rf_we and pushes into no transmit queue.
- R8: Every queue holds 4 words of 32 bits. net_in_ready drops once a receive queue holds 4 words.
- R9: Words leave each queue in the order they entered it.
- R10: An instruction with two mapped sources on different ports and a mapped destination issues without a stall when each source queue holds a word. Its result appears on the destination port.
- R11: After reset all queues are empty: net_in_ready is all ones and net_out_valid is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is in decode |
| src_a_idx | input | 5 | First source register number |
| src_b_idx | input | 5 | Second source register number |
| rf_a_data | input | 32 | Register-file value for the first source |
| rf_b_data | input | 32 | Register-file value for the second source |
| opnd_a | output | 32 | Resolved first operand |
| opnd_b | output | 32 | Resolved second operand |
| issue_stall | output | 1 | Hold the instruction in decode |
| wb_valid | input | 1 | A result is at writeback |
| wb_idx | input | 5 | Destination register number |
| wb_data | input | 32 | Result value |
| wb_stall | output | 1 | Hold the result at writeback |
| rf_we | output | 1 | Register-file write enable |
| net_in_valid | input | 4 | Receive word offered, one bit per port |
| net_in_data | input | 4x32 | Receive words, one per port |
| net_in_ready | output | 4 | Receive queue has space |
| net_out_valid | output | 4 | Transmit queue not empty |
| net_out_data | output | 4x32 | Front word of each transmit queue |
| net_out_ready | input | 4 | Network takes the front transmit word |

## Verification
The bench reads the same mapped register twice in one instruction. A design that peeked only the front word would hand the same value to both operands, or would remove only one word. It stalls reads on an empty queue and on a queue holding a single word when two are needed. This catches a design that issued early or removed words while stalled. It holds a result against a full transmit queue and then frees one slot, so a design that dropped the result or pushed it twice shows the wrong number of words when the queue drains. It also probes indices 23 and 28 to catch off-by-one errors in the mapped window.

// File: rtl/netreg_pkg.sv
package netreg_pkg;
    localparam int NR_DATA_W  = 32;
    localparam int NR_PORTS   = 4;
    localparam int NR_BASE    = 24;
    localparam int NR_DEPTH   = 4;
    localparam int NR_IDX_W   = 5;

    // True when a register number falls in the mapped window.
    function automatic logic in_window(input int idx, input int base, input int nports);
        return (idx >= base) && (idx < base + nports);
    endfunction
endpackage

// File: rtl/netreg_decode.sv
module netreg_decode #(
    parameter int IW   = 5,
    parameter int BASE = 24,
    parameter int NP   = 4,
    localparam int PW  = $clog2(NP)
) (
    input  logic [IW-1:0] idx,
    output logic          hit,
    output logic [PW-1:0] port
);
    always_comb begin
        hit  = netreg_pkg::in_window(int'(idx), BASE, NP);
        port = PW'(int'(idx) - BASE);
    end
endmodule

// File: rtl/netreg_fifo.sv
module netreg_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4,
    parameter int LOOK  = 1,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PNW  = $clog2(LOOK + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [W-1:0]             push_data,
    input  logic [PNW-1:0]           pop_n,
    output logic [LOOK-1:0][W-1:0]   peek,
    output logic [CW-1:0]            count
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr           = st_q.wr + AW'(1);
        end
        st_d.rd  = st_q.rd + AW'(pop_n);
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop_n);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar j = 0; j < LOOK; j++) begin : g_peek
        assign peek[j] = st_q.mem[st_q.rd + AW'(j)];
    end

    assign count = st_q.cnt;

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.cnt < CW'(DEPTH)));
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (CW'(pop_n) <= st_q.cnt));
endmodule

// File: rtl/netreg_if.sv
module netreg_if #(
    parameter int W     = netreg_pkg::NR_DATA_W,
    parameter int NP    = netreg_pkg::NR_PORTS,
    parameter int BASE  = netreg_pkg::NR_BASE,
    parameter int DEPTH = netreg_pkg::NR_DEPTH,
    parameter int IW    = netreg_pkg::NR_IDX_W,
    localparam int PW   = $clog2(NP),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_valid,
    input  logic [IW-1:0]        src_a_idx,
    input  logic [IW-1:0]        src_b_idx,
    input  logic [W-1:0]         rf_a_data,
    input  logic [W-1:0]         rf_b_data,
    output logic [W-1:0]         opnd_a,
    output logic [W-1:0]         opnd_b,
    output logic                 issue_stall,
    input  logic                 wb_valid,
    input  logic [IW-1:0]        wb_idx,
    input  logic [W-1:0]         wb_data,
    output logic                 wb_stall,
    output logic                 rf_we,
    input  logic [NP-1:0]        net_in_valid,
    input  logic [NP-1:0][W-1:0] net_in_data,
    output logic [NP-1:0]        net_in_ready,
    output logic [NP-1:0]        net_out_valid,
    output logic [NP-1:0][W-1:0] net_out_data,
    input  logic [NP-1:0]        net_out_ready
);
    logic          a_hit, b_hit, w_hit;
    logic [PW-1:0] a_port, b_port, w_port;

    netreg_decode #(.IW(IW), .BASE(BASE), .NP(NP)) u_dec_a (.idx(src_a_idx), .hit(a_hit), .port(a_port));
    netreg_decode #(.IW(IW), .BASE(BASE), .NP(NP)) u_dec_b (.idx(src_b_idx), .hit(b_hit), .port(b_port));
    netreg_decode #(.IW(IW), .BASE(BASE), .NP(NP)) u_dec_w (.idx(wb_idx),    .hit(w_hit), .port(w_port));

    logic [NP-1:0][1:0]        need;
    logic [NP-1:0]             short_q;
    logic [NP-1:0][1:0]        in_pop;
    logic [NP-1:0]             in_push;
    logic [NP-1:0][CW-1:0]     in_cnt;
    logic [NP-1:0][1:0][W-1:0] in_peek;
    logic [NP-1:0]             out_push;
    logic [NP-1:0]             out_pop;
    logic [NP-1:0][CW-1:0]     out_cnt;
    logic [NP-1:0][0:0][W-1:0] out_peek;
    logic                      issue_fire;
    logic                      same_port;

    always_comb begin
        same_port   = a_hit && b_hit && (a_port == b_port);
        issue_stall = issue_valid && (|short_q);
        issue_fire  = issue_valid && !issue_stall;
        opnd_a      = a_hit ? in_peek[a_port][0] : rf_a_data;
        if (!b_hit)         opnd_b = rf_b_data;
        else if (same_port) opnd_b = in_peek[b_port][1];
        else                opnd_b = in_peek[b_port][0];
        wb_stall    = wb_valid && w_hit && (out_cnt[w_port] == CW'(DEPTH));
        rf_we       = wb_valid && !w_hit;
    end

    for (genvar k = 0; k < NP; k++) begin : g_port
        assign need[k]          = 2'(a_hit && (a_port == PW'(k))) + 2'(b_hit && (b_port == PW'(k)));
        assign short_q[k]       = CW'(need[k]) > in_cnt[k];
        assign in_pop[k]        = issue_fire ? need[k] : 2'd0;
        assign net_in_ready[k]  = in_cnt[k] < CW'(DEPTH);
        assign in_push[k]       = net_in_valid[k] && net_in_ready[k];
        assign out_push[k]      = wb_valid && w_hit && (w_port == PW'(k)) && !wb_stall;
        assign net_out_valid[k] = out_cnt[k] != '0;
        assign out_pop[k]       = net_out_valid[k] && net_out_ready[k];
        assign net_out_data[k]  = out_peek[k][0];

        netreg_fifo #(.W(W), .DEPTH(DEPTH), .LOOK(2)) u_rxq (
            .clk(clk), .rst_n(rst_n),
            .push(in_push[k]), .push_data(net_in_data[k]),
            .pop_n(in_pop[k]), .peek(in_peek[k]), .count(in_cnt[k])
        );

        netreg_fifo #(.W(W), .DEPTH(DEPTH), .LOOK(1)) u_txq (
            .clk(clk), .rst_n(rst_n),
            .push(out_push[k]), .push_data(wb_data),
            .pop_n(out_pop[k]), .peek(out_peek[k]), .count(out_cnt[k])
        );
    end

    a_r4_stall_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && a_hit && (in_cnt[a_port] == '0)) |-> issue_stall);
    a_r3_stall_on_single: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && same_port && (in_cnt[a_port] < CW'(2))) |-> issue_stall);
    a_r6_stall_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && w_hit && (out_cnt[w_port] == CW'(DEPTH))) |-> wb_stall);
    a_r1_plain_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !a_hit && !b_hit) |-> !issue_stall);
endmodule

// File: tb/test_netreg_if.sv
`timescale 1ns/1ps
module test_netreg_if;
    logic             clk = 1'b0;
    logic             rst_n;
    logic             issue_valid;
    logic [4:0]       src_a_idx, src_b_idx;
    logic [31:0]      rf_a_data, rf_b_data;
    logic [31:0]      opnd_a, opnd_b;
    logic             issue_stall;
    logic             wb_valid;
    logic [4:0]       wb_idx;
    logic [31:0]      wb_data;
    logic             wb_stall, rf_we;
    logic [3:0]       net_in_valid;
    logic [3:0][31:0] net_in_data;
    logic [3:0]       net_in_ready;
    logic [3:0]       net_out_valid;
    logic [3:0][31:0] net_out_data;
    logic [3:0]       net_out_ready;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    netreg_if i_netreg_if (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
        .rf_a_data(rf_a_data), .rf_b_data(rf_b_data),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .issue_stall(issue_stall),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
        .wb_stall(wb_stall), .rf_we(rf_we),
        .net_in_valid(net_in_valid), .net_in_data(net_in_data), .net_in_ready(net_in_ready),
        .net_out_valid(net_out_valid), .net_out_data(net_out_data), .net_out_ready(net_out_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_in(input int k, input logic [31:0] d);
        net_in_valid[k] = 1'b1;
        net_in_data[k]  = d;
        step();
        net_in_valid[k] = 1'b0;
    endtask

    task automatic drain_out(input int k, input logic [31:0] exp, input string req);
        #1;
        chk(req, 32'(net_out_valid[k]), 32'd1);
        chk(req, net_out_data[k], exp);
        net_out_ready[k] = 1'b1;
        step();
        net_out_ready[k] = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        chk("R11 in ready", 32'(net_in_ready), 32'hF);
        chk("R11 out valid", 32'(net_out_valid), 32'h0);
        chk("R11 no stall", 32'(issue_stall), 32'd0);
    endtask

    task automatic t_plain();
        issue_valid = 1'b1; src_a_idx = 5'd3; src_b_idx = 5'd23;
        rf_a_data = 32'h1111_0003; rf_b_data = 32'h2222_0023;
        #1;
        chk("R1 opnd_a rf", opnd_a, 32'h1111_0003);
        chk("R1 opnd_b idx23", opnd_b, 32'h2222_0023);
        chk("R1 no stall", 32'(issue_stall), 32'd0);
        src_a_idx = 5'd28; src_b_idx = 5'd31;
        #1;
        chk("R1 idx28 rf", opnd_a, 32'h1111_0003);
        chk("R1 idx28 no stall", 32'(issue_stall), 32'd0);
        step();
        issue_valid = 1'b0; src_a_idx = 5'd0; src_b_idx = 5'd0;
    endtask

    task automatic t_single();
        send_in(1, 32'hA001);
        send_in(1, 32'hA002);
        issue_valid = 1'b1; src_a_idx = 5'd25; src_b_idx = 5'd0;
        #1;
        chk("R2 head", opnd_a, 32'hA001);
        chk("R2 no stall", 32'(issue_stall), 32'd0);
        step();
        #1;
        chk("R9 second word", opnd_a, 32'hA002);
        step();
        #1;
        chk("R4 stall empty", 32'(issue_stall), 32'd1);
        step();
        #1;
        chk("R4 still stalled", 32'(issue_stall), 32'd1);
        net_in_valid[1] = 1'b1; net_in_data[1] = 32'hA003;
        #1;
        chk("R4 stall in arrival cycle", 32'(issue_stall), 32'd1);
        step();
        net_in_valid[1] = 1'b0;
        #1;
        chk("R4 released", 32'(issue_stall), 32'd0);
        chk("R4 word delivered", opnd_a, 32'hA003);
        step();
        issue_valid = 1'b0; src_a_idx = 5'd0;
        #1;
        chk("R2 queue emptied", 32'(net_in_ready[1]), 32'd1);
    endtask

    task automatic t_same();
        send_in(2, 32'hB001);
        issue_valid = 1'b1; src_a_idx = 5'd26; src_b_idx = 5'd26;
        #1;
        chk("R3 stall one word", 32'(issue_stall), 32'd1);
        step();
        issue_valid = 1'b0;
        send_in(2, 32'hB002);
        issue_valid = 1'b1;
        #1;
        chk("R3 no stall two words", 32'(issue_stall), 32'd0);
        chk("R3 first to a", opnd_a, 32'hB001);
        chk("R3 second to b", opnd_b, 32'hB002);
        step();
        #1;
        chk("R3 both consumed", 32'(issue_stall), 32'd1);
        issue_valid = 1'b0; src_a_idx = 5'd0; src_b_idx = 5'd0;
        step();
    endtask

    task automatic t_full();
        for (int i = 0; i < 4; i++) begin
            #1;
            chk("R8 ready before full", 32'(net_in_ready[3]), 32'd1);
            send_in(3, 32'hC000 + 32'(i));
        end
        #1;
        chk("R8 ready low when full", 32'(net_in_ready[3]), 32'd0);
        issue_valid = 1'b1; src_a_idx = 5'd0; src_b_idx = 5'd27;
        for (int i = 0; i < 4; i++) begin
            #1;
            chk("R9 order", opnd_b, 32'hC000 + 32'(i));
            step();
        end
        #1;
        chk("R9 drained", 32'(issue_stall), 32'd1);
        issue_valid = 1'b0; src_b_idx = 5'd0;
        step();
    endtask

    task automatic t_wb();
        wb_valid = 1'b1; wb_idx = 5'd24; wb_data = 32'hD024;
        #1;
        chk("R5 no rf write", 32'(rf_we), 32'd0);
        step();
        wb_valid = 1'b0;
        #1;
        chk("R5 only port0", 32'(net_out_valid), 32'h1);
        drain_out(0, 32'hD024, "R5 data");
        wb_valid = 1'b1; wb_idx = 5'd10; wb_data = 32'hD010;
        #1;
        chk("R7 rf write", 32'(rf_we), 32'd1);
        wb_idx = 5'd28;
        #1;
        chk("R7 idx28 rf write", 32'(rf_we), 32'd1);
        step();
        wb_valid = 1'b0;
        #1;
        chk("R7 no push", 32'(net_out_valid), 32'h0);
    endtask

    task automatic t_wb_full();
        for (int i = 0; i < 4; i++) begin
            wb_valid = 1'b1; wb_idx = 5'd25; wb_data = 32'hE000 + 32'(i);
            #1;
            chk("R6 no stall with space", 32'(wb_stall), 32'd0);
            step();
        end
        wb_data = 32'hE004;
        #1;
        chk("R6 stall when full", 32'(wb_stall), 32'd1);
        step();
        #1;
        chk("R6 still stalled", 32'(wb_stall), 32'd1);
        chk("R6 head kept", net_out_data[1], 32'hE000);
        net_out_ready[1] = 1'b1;
        #1;
        chk("R6 stall in free cycle", 32'(wb_stall), 32'd1);
        step();
        net_out_ready[1] = 1'b0;
        #1;
        chk("R6 stall released", 32'(wb_stall), 32'd0);
        step();
        wb_valid = 1'b0;
        for (int j = 1; j < 5; j++) drain_out(1, 32'hE000 + 32'(j), "R6 drain");
        #1;
        chk("R6 pushed once", 32'(net_out_valid[1]), 32'd0);
    endtask

    task automatic t_flow();
        logic [31:0] sum;
        send_in(0, 32'd100);
        send_in(1, 32'd23);
        issue_valid = 1'b1; src_a_idx = 5'd24; src_b_idx = 5'd25;
        #1;
        chk("R10 no stall", 32'(issue_stall), 32'd0);
        chk("R10 opnd_a", opnd_a, 32'd100);
        chk("R10 opnd_b", opnd_b, 32'd23);
        sum = opnd_a + opnd_b;
        step();
        #1;
        chk("R10 sources consumed", 32'(issue_stall), 32'd1);
        issue_valid = 1'b0; src_a_idx = 5'd0; src_b_idx = 5'd0;
        wb_valid = 1'b1; wb_idx = 5'd26; wb_data = sum;
        step();
        wb_valid = 1'b0;
        drain_out(2, 32'd123, "R10 result sent");
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; issue_valid = 1'b0; src_a_idx = '0; src_b_idx = '0;
        rf_a_data = '0; rf_b_data = '0; wb_valid = 1'b0; wb_idx = '0; wb_data = '0;
        net_in_valid = '0; net_in_data = '0; net_out_ready = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_single();
        t_same();
        t_full();
        t_wb();
        t_wb_full();
        t_flow();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule